// File: doc/BRIEF.md
# Bounded Overcurrent Retry Controller

This block sits beside a hot-plug power switch and decides, from two digital comparator flags, whether the switch gate may be driven. One flag reports that the sensed load current has hit the regulation ceiling. While it is high, an external analog loop holds the gate at that ceiling. The second flag reports that the sensed current has fallen under the lower breaker threshold. The block times how long current regulation lasts. If it lasts too long, the block records a fault and forces the gate off for a long cool-down. It then tries again.

The cool-down is derived from the regulation window so that on-time over off-time equals a fixed percentage. After a set number of faults in a row, the block gives up and latches off until the supervisor drops its enable or reset is applied. When a retry reaches a clean state, the consecutive-fault tally is cleared. A clean state means the ceiling flag is low and the breaker flag is high. A fault that goes away between retries therefore does not count toward the latch-off limit.

Top module: `ocp_retry_ctrl`

## Requirements
- R1: A fault is declared at the rising edge on which `over_limit` has been sampled high on LIMIT_CYCLES consecutive rising edges while the gate is driven. At that edge `fault_count` increments and `gate_on` goes low.
- R2: If `over_limit` is sampled low on any edge before the window completes, the count restarts and no fault is declared.
- R3: After a fault that does not latch, `gate_on` stays low for exactly OFF_CYCLES = floor(LIMIT_CYCLES*100/ON_OFF_PCT) cycles and then returns high.
- R4: `limiting` is high exactly when the gate is driven in the running state and `over_limit` is high. It is low while the gate is off or latched.
- R5: The fault that brings `fault_count` to MAX_FAULTS (default 7) sets `latched_off` and holds `gate_on` low. Both hold, whatever `over_limit` and `below_breaker` do, for as long as `enable` stays high.
- R6: `fault_count` returns to 0 on an edge where the gate is driven, `over_limit` is low and `below_breaker` is high. While both flags are low it holds its value.
- R7: With `enable` low, the block is idle from the next edge: `gate_on` low, `fault_count` 0 and `latched_off` low. Raising `enable` drives the gate from the next edge.
- R8: After reset, `gate_on`, `limiting` and `latched_off` are low and `fault_count` is 0.
- R9: `fault_count` is 3 bits wide by default and never wraps. It saturates at its top value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Supervisor permission to power the load |
| over_limit | input | 1 | Current at regulation ceiling |
| below_breaker | input | 1 | Current under breaker release threshold |
| gate_on | output | 1 | Drive the power switch gate |
| limiting | output | 1 | Gate is under current regulation |
| fault_count | output | CNT_W | Consecutive faults recorded |
| latched_off | output | 1 | Retry limit reached, gate held off |

## Verification
A regulation timer that is off by one shows at the ports as `gate_on` dropping one edge early or late. The bench probes the edge before and the edge of the fault. An off-period error shows as the gate returning at the wrong edge after the long cool-down, and the bench checks the cycle before and the cycle of return. A tally that is cleared too eagerly or too late shows as a wrong `fault_count` within one cycle of the flags changing. It also shows as latch-off arriving at a different edge from the one predicted across seven retries.

// File: rtl/ocp_retry_pkg.sv
package ocp_retry_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ON    = 2'd1,
      ST_COOL  = 2'd2,
      ST_LATCH = 2'd3
   } retry_state_t;
endpackage

// File: rtl/ocp_span_timer.sv
module ocp_span_timer #(
   parameter int SPAN = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic done
);
   localparam int W = (SPAN > 1) ? $clog2(SPAN) : 1;
   localparam logic [W-1:0] LAST = W'(SPAN - 1);

   generate
      if (SPAN < 2) begin : g_bad_span
         $error("ocp_span_timer: SPAN must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt;

   assign done = run && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (rst || !run || done) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
   end

   // R1 / R3: the interval counter never runs past its last value
   a_r1_no_overflow: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);
   // R2: an interrupted run restarts from zero
   a_r2_restart: assert property (@(posedge clk) disable iff (rst) !run |=> cnt == '0);
endmodule

// File: rtl/ocp_fault_tally.sv
module ocp_fault_tally #(
   parameter int MAX_FAULTS = 7,
   parameter int CNT_W      = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] count,
   output logic             at_limit
);
   localparam logic [CNT_W-1:0] PRE_LIMIT = CNT_W'(MAX_FAULTS - 1);
   localparam logic [CNT_W-1:0] TOP       = {CNT_W{1'b1}};

   generate
      if (MAX_FAULTS < 1 || MAX_FAULTS > (2**CNT_W - 1)) begin : g_bad_limit
         $error("ocp_fault_tally: MAX_FAULTS must fit in CNT_W bits");
      end
   endgenerate

   assign at_limit = inc && (count == PRE_LIMIT);

   always_ff @(posedge clk) begin
      if (rst || clr)               count <= '0;
      else if (inc && count != TOP) count <= count + 1'b1;
   end

   // R9: the tally only steps up by one or returns to zero
   a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
      (count != $past(count)) |-> (count == '0 || count == $past(count) + 1'b1));
   // R6: a clear request empties the tally
   a_r6_clear: assert property (@(posedge clk) disable iff (rst) clr |=> count == '0);
endmodule

// File: rtl/ocp_retry_ctrl.sv
module ocp_retry_ctrl #(
   parameter int LIMIT_CYCLES = 14000,
   parameter int ON_OFF_PCT   = 3,
   parameter int MAX_FAULTS   = 7,
   parameter int CNT_W        = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             enable,
   input  logic             over_limit,
   input  logic             below_breaker,
   output logic             gate_on,
   output logic             limiting,
   output logic [CNT_W-1:0] fault_count,
   output logic             latched_off
);
   import ocp_retry_pkg::*;

   localparam int OFF_CYCLES = (LIMIT_CYCLES * 100) / ON_OFF_PCT;

   generate
      if (ON_OFF_PCT < 1 || ON_OFF_PCT > 100) begin : g_bad_ratio
         $error("ocp_retry_ctrl: ON_OFF_PCT out of range");
      end
   endgenerate

   retry_state_t state, state_nx;
   logic limit_run, limit_done;
   logic cool_run, cool_done;
   logic tally_clr, tally_last;

   assign limit_run = (state == ST_ON) && over_limit && enable;
   assign cool_run  = (state == ST_COOL) && enable;

   ocp_span_timer #(.SPAN(LIMIT_CYCLES)) u_limit_timer (
      .clk (clk), .rst (rst), .run (limit_run), .done (limit_done)
   );

   ocp_span_timer #(.SPAN(OFF_CYCLES)) u_cool_timer (
      .clk (clk), .rst (rst), .run (cool_run), .done (cool_done)
   );

   assign tally_clr = !enable ||
                      ((state == ST_ON) && !over_limit && below_breaker);

   ocp_fault_tally #(.MAX_FAULTS(MAX_FAULTS), .CNT_W(CNT_W)) u_tally (
      .clk (clk), .rst (rst), .clr (tally_clr), .inc (limit_done),
      .count (fault_count), .at_limit (tally_last)
   );

   always_comb begin
      state_nx = state;
      if (!enable) state_nx = ST_IDLE;
      else begin
         unique case (state)
            ST_IDLE:  state_nx = ST_ON;
            ST_ON:    if (limit_done) state_nx = tally_last ? ST_LATCH : ST_COOL;
            ST_COOL:  if (cool_done)  state_nx = ST_ON;
            ST_LATCH: state_nx = ST_LATCH;
            default:  state_nx = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) state <= ST_IDLE;
      else     state <= state_nx;
   end

   assign gate_on     = (state == ST_ON);
   assign latched_off = (state == ST_LATCH);
   assign limiting    = gate_on && over_limit;

   // R1: a completed regulation window turns the gate off
   a_r1_fault_drops_gate: assert property (@(posedge clk) disable iff (rst)
      limit_done |=> !gate_on);
   // R3: end of cool-down brings the gate back
   a_r3_cool_to_on: assert property (@(posedge clk) disable iff (rst)
      cool_done |=> gate_on);
   // R4: regulation is only reported with the gate driven
   a_r4_limit_needs_gate: assert property (@(posedge clk) disable iff (rst)
      limiting |-> gate_on && !latched_off);
   // R5: latch-off persists while enabled
   a_r5_latch_hold: assert property (@(posedge clk) disable iff (rst)
      latched_off && enable |=> latched_off && !gate_on);
   // R7: dropping enable idles the block
   a_r7_disable_idle: assert property (@(posedge clk) disable iff (rst)
      !enable |=> !gate_on && !latched_off && fault_count == '0);
endmodule

// File: tb/ocp_retry_ctrl_tb.sv
module ocp_retry_ctrl_tb;
   localparam int LIM = 5;
   localparam int PCT = 3;
   localparam int OFF = (LIM * 100) / PCT;
   localparam int MAXF = 7;

   logic clk = 1'b0;
   logic rst, enable, over_limit, below_breaker;
   logic gate_on, limiting, latched_off;
   logic [2:0] fault_count;
   int n_run = 0;
   int n_fail = 0;
   bit done_flag = 0;

   always #4 clk = ~clk;

   ocp_retry_ctrl #(.LIMIT_CYCLES(LIM), .ON_OFF_PCT(PCT), .MAX_FAULTS(MAXF), .CNT_W(3)) u_dut (
      .clk (clk), .rst (rst), .enable (enable), .over_limit (over_limit),
      .below_breaker (below_breaker), .gate_on (gate_on), .limiting (limiting),
      .fault_count (fault_count), .latched_off (latched_off)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      rst = 1; enable = 0; over_limit = 0; below_breaker = 1;
      tick(3);
      rst = 0;
      tick(1);
      chk("R8 gate_on", gate_on, 0);
      chk("R8 limiting", limiting, 0);
      chk("R8 count", fault_count, 0);
      chk("R8 latched", latched_off, 0);
   endtask

   task automatic t_enable();
      enable = 1;
      tick(1);
      chk("R7 gate after enable", gate_on, 1);
      chk("R4 no limiting", limiting, 0);
   endtask

   task automatic t_window_restart();
      over_limit = 1; below_breaker = 0;
      tick(LIM - 1);
      chk("R4 limiting", limiting, 1);
      over_limit = 0;
      tick(1);
      over_limit = 1;
      tick(LIM - 1);
      chk("R2 gate still on", gate_on, 1);
      chk("R2 no fault", fault_count, 0);
      over_limit = 0; below_breaker = 1;
      tick(2);
   endtask

   task automatic t_single_fault();
      over_limit = 1; below_breaker = 0;
      tick(LIM - 1);
      chk("R1 gate before window end", gate_on, 1);
      tick(1);
      chk("R1 gate after fault", gate_on, 0);
      chk("R1 count", fault_count, 1);
      chk("R4 limiting off in cool", limiting, 0);
      over_limit = 0;
      tick(OFF - 1);
      chk("R3 gate still off", gate_on, 0);
      tick(1);
      chk("R3 gate back", gate_on, 1);
      tick(3);
      chk("R6 hold with flags low", fault_count, 1);
      below_breaker = 1;
      tick(1);
      chk("R6 cleared", fault_count, 0);
   endtask

   task automatic t_latch();
      over_limit = 1; below_breaker = 0;
      tick(LIM);
      chk("R1 first fault", fault_count, 1);
      tick((MAXF - 1) * (OFF + LIM) - 1);
      chk("R5 before last fault count", fault_count, MAXF - 1);
      chk("R5 before last latched", latched_off, 0);
      tick(1);
      chk("R5 latched", latched_off, 1);
      chk("R5 gate off", gate_on, 0);
      chk("R9 count at top", fault_count, 7);
      below_breaker = 1; over_limit = 0;
      tick(OFF + 20);
      chk("R5 still latched", latched_off, 1);
      chk("R5 gate held", gate_on, 0);
      chk("R9 no wrap", fault_count, 7);
      over_limit = 1;
      tick(2);
      chk("R4 no limiting when latched", limiting, 0);
      over_limit = 0;
      enable = 0;
      tick(1);
      chk("R7 latch cleared", latched_off, 0);
      chk("R7 count cleared", fault_count, 0);
      chk("R7 gate off", gate_on, 0);
      enable = 1;
      tick(1);
      chk("R7 gate after re-enable", gate_on, 1);
   endtask

   initial begin
      rst = 1; enable = 0; over_limit = 0; below_breaker = 1;
      do_reset();
      t_enable();
      t_window_restart();
      t_single_fault();
      t_latch();
      if (!done_flag) begin
         done_flag = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done_flag) begin
         done_flag = 1;
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule